// File: doc/BRIEF.md
# SPI Slave Register Port

This block lets a host processor configure a chip over a four-wire serial link. The host pulls the active-low select low, then sends a command byte, an address byte and one or more data bytes. All bytes travel most significant bit first. A write command stores each data byte into an 8-bit register file. A read command returns register contents on the serial output. In both cases the address steps by one after every data byte, so a single select period can cover a burst of consecutive registers.

The serial pins are brought into the block's system clock through a synchronizer, and the block detects the serial clock edges there. The serial clock idles low. Input bits are taken on the rising edge of the serial clock, and read data changes after the falling edge.

Offset 0 and the upper seven bits of offset 1 hold a fixed chip identity. Bit 0 of offset 1 is a run control for the surrounding switch, which software sets only after it has written and verified the configuration. All registers are visible to the rest of the chip on a flat bus.

Top module: `spi_regport`

## Requirements
- R1: While the select is high the output enable `spi_miso_oe` is 0. Within 4 system clocks after the select goes low it is 1, and it returns to 0 within 4 clocks after the select goes high.
- R2: Each transfer is a command byte, then an address byte, then data bytes. Every byte is sent most significant bit first, and each bit is taken on a rising edge of the serial clock. Only the low `ADDR_W` bits of the address byte are used.
- R3: Command 0x02 writes each complete data byte to the current address. The new value appears on `cfg_flat[8*a +: 8]`.
- R4: Command 0x03 returns the byte at the current address on `spi_miso`, most significant bit first. The first bit is valid after the falling serial clock edge that follows the last address bit, and each later bit changes only after a falling edge.
- R5: In both read and write bursts the address increments after each data byte and wraps from 0x7F to 0x00.
- R6: A command byte other than 0x02 or 0x03 causes all following bytes to be ignored until the select goes high. No register changes, and the next transfer is decoded normally.
- R7: If the select goes high in the middle of a byte, that partial byte is not written. Complete bytes written earlier in the same burst are kept.
- R8: Offset 0 reads `CHIP_ID0`. Bits 7:1 of offset 1 read `CHIP_ID1_HI`. Writes never change these bits.
- R9: `run_en` equals bit 0 of offset 1. It is changed only by a write to offset 1.
- R10: After reset, `run_en` is 0, `spi_miso_oe` is 0, and every writable register bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Enable for the output pad; the pad is high impedance when 0 |
| run_en | output | 1 | Switch run control, bit 0 of offset 1 |
| cfg_flat | output | 8*2^ADDR_W | All registers; register a is bits 8*a+7 to 8*a |

## Verification
A change on a serial pin passes two synchronizer flops before the control logic acts on it at the third system clock edge. A completed write byte reaches its register on that same edge. `spi_miso` moves one edge after the falling serial clock edge has been detected, and the output enable follows the select with the same latency. The bench therefore holds each serial clock phase for 8 system clocks and samples `spi_miso` just before each rising edge, as a host would. It reads `cfg_flat`, `run_en` and the output enable only after waiting at least 16 clocks once the select has been released.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } phase_e;

   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h02;
   localparam logic [BYTE_W-1:0] CMD_READ  = 8'h03;
   localparam int unsigned RUN_OFFSET = 1;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_pin,
   input  logic cs_n_pin,
   input  logic mosi_pin,
   output logic sel,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s
);
   // bit 0 = sck, bit 1 = cs_n, bit 2 = mosi
   localparam logic [2:0] IDLE_PINS = 3'b010;

   logic [2:0] stg [STAGES];
   logic       sck_prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= IDLE_PINS;
            else        stg[0] <= {mosi_pin, cs_n_pin, sck_pin};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= IDLE_PINS;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= stg[STAGES-1][0];
   end

   assign sel      = ~stg[STAGES-1][1];
   assign mosi_s   = stg[STAGES-1][2];
   assign sck_rise = sel &  stg[STAGES-1][0] & ~sck_prev;
   assign sck_fall = sel & ~stg[STAGES-1][0] &  sck_prev;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_regport_pkg::*;
#(
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              miso,
   output logic              miso_oe
);
   localparam int unsigned CNT_W = $clog2(BYTE_W);

   if (ADDR_W > BYTE_W || ADDR_W < 1) begin : g_bad_addr
      $error("spi_frame_ctrl: ADDR_W must lie in 1..8");
   end

   phase_e              phase_q;
   logic                is_wr_q;
   logic [CNT_W-1:0]    bit_q;
   logic [BYTE_W-2:0]   rx_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [BYTE_W-1:0]   tx_q;
   logic                oe_q;
   logic [BYTE_W-1:0]   byte_w;
   logic                byte_done;
   logic                last_bit;

   assign last_bit  = (bit_q == CNT_W'(BYTE_W - 1));
   assign byte_w    = {rx_q, mosi};
   assign byte_done = sel & sck_rise & last_bit;

   // receive side: bit counter, shifter and phase sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         is_wr_q <= 1'b0;
         bit_q   <= '0;
         rx_q    <= '0;
         addr_q  <= '0;
      end else if (!sel) begin
         phase_q <= PH_CMD;
         is_wr_q <= 1'b0;
         bit_q   <= '0;
      end else if (sck_rise) begin
         rx_q  <= byte_w[BYTE_W-2:0];
         bit_q <= bit_q + 1'b1;
         if (last_bit) begin
            unique case (phase_q)
               PH_CMD: begin
                  if (byte_w == CMD_WRITE) begin
                     phase_q <= PH_ADDR;
                     is_wr_q <= 1'b1;
                  end else if (byte_w == CMD_READ) begin
                     phase_q <= PH_ADDR;
                     is_wr_q <= 1'b0;
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
               PH_ADDR: begin
                  addr_q  <= byte_w[ADDR_W-1:0];
                  phase_q <= PH_DATA;
               end
               PH_DATA: addr_q <= addr_q + 1'b1;
               PH_SKIP: phase_q <= PH_SKIP;
               default: phase_q <= PH_SKIP;
            endcase
         end
      end
   end

   // transmit side: load at a byte boundary of a read, else shift
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (sck_fall) begin
         if (phase_q == PH_DATA && !is_wr_q && bit_q == '0) tx_q <= rd_data;
         else tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= sel;
   end

   assign wr_en   = byte_done & (phase_q == PH_DATA) & is_wr_q;
   assign wr_addr = addr_q;
   assign wr_data = byte_w;
   assign rd_addr = addr_q;
   assign miso    = tx_q[BYTE_W-1];
   assign miso_oe = oe_q;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && $past(sel) && $past(byte_done && phase_q == PH_DATA))
      |-> (addr_q == $past(addr_q) + 1'b1)); // R5
   AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase_q == PH_SKIP) && sel) |-> (phase_q == PH_SKIP)); // R6
   AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sck_fall) |-> $stable(tx_q)); // R4
   AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sel) |-> !miso_oe); // R1

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
   import spi_regport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter logic [7:0]  CHIP_ID0    = 8'h95,
   parameter logic [6:0]  CHIP_ID1_HI = 7'h30
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [BYTE_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [BYTE_W-1:0]            rd_data,
   output logic [(BYTE_W<<ADDR_W)-1:0]  cfg_flat,
   output logic                         run_en
);
   localparam int unsigned NREG = 1 << ADDR_W;

   if (NREG < 2) begin : g_bad_depth
      $error("spi_regfile: at least two registers are required");
   end

   logic [BYTE_W-1:0] regs_v [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam logic [BYTE_W-1:0] WMASK =
         (k == 0)          ? 8'h00 :
         (k == RUN_OFFSET) ? 8'h01 : 8'hFF;
      localparam logic [BYTE_W-1:0] RVAL =
         (k == 0)          ? CHIP_ID0 :
         (k == RUN_OFFSET) ? {CHIP_ID1_HI, 1'b0} : 8'h00;

      if (WMASK == 8'h00) begin : g_const
         assign regs_v[k] = RVAL;
      end else begin : g_store
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RVAL;
            else if (wr_en && wr_addr == ADDR_W'(k))
               q <= (q & ~WMASK) | (wr_data & WMASK);
         end
         assign regs_v[k] = q;
      end
      assign cfg_flat[k*BYTE_W +: BYTE_W] = regs_v[k];
   end

   assign rd_data = regs_v[rd_addr];
   assign run_en  = regs_v[RUN_OFFSET][0];

   AST_ID0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      regs_v[0] == CHIP_ID0); // R8
   AST_ID1_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs_v[RUN_OFFSET][7:1])); // R8
   AST_RUN_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run_en) |-> $past(wr_en && wr_addr == ADDR_W'(RUN_OFFSET))); // R9

endmodule

// File: rtl/spi_regport.sv
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  CHIP_ID0    = 8'h95,
   parameter logic [6:0]  CHIP_ID1_HI = 7'h30
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          spi_sck,
   input  logic                          spi_cs_n,
   input  logic                          spi_mosi,
   output logic                          spi_miso,
   output logic                          spi_miso_oe,
   output logic                          run_en,
   output logic [(BYTE_W<<ADDR_W)-1:0]   cfg_flat
);
   logic              sel, sck_rise, sck_fall, mosi_s;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [BYTE_W-1:0] wr_data, rd_data;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .sck_pin(spi_sck), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
      .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
   );

   spi_frame_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(mosi_s),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .miso(spi_miso), .miso_oe(spi_miso_oe)
   );

   spi_regfile #(.ADDR_W(ADDR_W), .CHIP_ID0(CHIP_ID0), .CHIP_ID1_HI(CHIP_ID1_HI)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .cfg_flat(cfg_flat), .run_en(run_en)
   );

   AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !wr_en); // R7

endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
   localparam logic [7:0] ID0 = 8'h95;
   localparam logic [6:0] ID1 = 7'h31;
   localparam int HALF = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso, miso_oe, run_en;
   logic [1023:0] cfg;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   spi_regport #(.ADDR_W(7), .SYNC_STAGES(2), .CHIP_ID0(ID0), .CHIP_ID1_HI(ID1)) i_spi_regport (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .run_en(run_en), .cfg_flat(cfg)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_at(input int a);
      return cfg[a*8 +: 8];
   endfunction

   task automatic sel_on();
      cs_n = 1'b0;
      #(HALF);
   endtask

   task automatic sel_off();
      #(HALF);
      cs_n = 1'b1;
      #(2*HALF);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         #(HALF);
         rx[i] = miso;
         sck = 1'b1;
         #(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic wr1(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] r;
      sel_on();
      xfer(8'h02, r); xfer(a, r); xfer(d, r);
      sel_off();
   endtask

   task automatic rd1(input logic [7:0] a, output logic [7:0] d);
      logic [7:0] r;
      sel_on();
      xfer(8'h03, r); xfer(a, r); xfer(8'h00, d);
      sel_off();
   endtask

   task automatic t_reset();
      check("R10 oe after reset", miso_oe, 0);
      check("R10 run_en after reset", run_en, 0);
      check("R10 reg 0x05 after reset", reg_at(5), 0);
   endtask

   task automatic t_single();
      logic [7:0] r;
      wr1(8'h05, 8'hA5);
      check("R3 R2 single write 0x05", reg_at(5), 8'hA5);
      rd1(8'h05, r);
      check("R4 single read 0x05", r, 8'hA5);
      wr1(8'h06, 8'h3C);
      rd1(8'h06, r);
      check("R4 R2 single read 0x06", r, 8'h3C);
   endtask

   task automatic t_oe();
      logic [7:0] r;
      sel_on();
      check("R1 oe while selected", miso_oe, 1);
      xfer(8'h03, r);
      sel_off();
      check("R1 oe after release", miso_oe, 0);
   endtask

   task automatic t_burst_wrap();
      logic [7:0] r, a, b, c;
      sel_on();
      xfer(8'h02, r); xfer(8'h7E, r);
      xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r);
      sel_off();
      check("R5 burst write 0x7E", reg_at(8'h7E), 8'h11);
      check("R5 burst write 0x7F", reg_at(8'h7F), 8'h22);
      check("R8 wrap write to 0x00 ignored", reg_at(0), ID0);
      sel_on();
      xfer(8'h03, r); xfer(8'h7F, r);
      xfer(8'h00, a); xfer(8'h00, b); xfer(8'h00, c);
      sel_off();
      check("R5 burst read 0x7F", a, 8'h22);
      check("R5 R8 burst read wrap 0x00", b, ID0);
      check("R5 R8 burst read 0x01", c, {ID1, 1'b0});
   endtask

   task automatic t_bad_cmd();
      logic [7:0] r;
      sel_on();
      xfer(8'h07, r); xfer(8'h05, r); xfer(8'h3C, r);
      sel_off();
      check("R6 unknown command leaves 0x05", reg_at(5), 8'hA5);
      sel_on();
      xfer(8'h82, r); xfer(8'h01, r); xfer(8'h01, r);
      sel_off();
      check("R6 unknown command leaves run_en", run_en, 0);
      rd1(8'h05, r);
      check("R6 next transfer decoded", r, 8'hA5);
   endtask

   task automatic t_abort();
      logic [7:0] r;
      sel_on();
      xfer(8'h02, r); xfer(8'h10, r); xfer(8'h77, r);
      for (int i = 0; i < 4; i++) begin
         mosi = 1'b1;
         #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
      end
      sel_off();
      check("R7 complete byte kept", reg_at(8'h10), 8'h77);
      check("R7 partial byte dropped", reg_at(8'h11), 8'h00);
   endtask

   task automatic t_id_run();
      logic [7:0] r;
      wr1(8'h00, 8'hFF);
      check("R8 offset 0 read-only", reg_at(0), ID0);
      wr1(8'h01, 8'hFE);
      check("R8 offset 1 id bits read-only", reg_at(1), {ID1, 1'b0});
      check("R9 run_en stays 0", run_en, 0);
      wr1(8'h01, 8'h01);
      check("R9 run_en set by write", run_en, 1);
      rd1(8'h01, r);
      check("R9 R8 read offset 1", r, {ID1, 1'b1});
      rd1(8'h00, r);
      check("R8 read offset 0", r, ID0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #100;
      rst_n = 1'b1;
      #100;
      t_reset();
      t_single();
      t_oe();
      t_burst_wrap();
      t_bad_cmd();
      t_abort();
      t_id_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule